// File: doc/BRIEF.md
# LIN Frame Response Monitor

This block sits in the master node of a single-wire body network. It checks each frame once the header is on the bus. The break/start of a frame is marked by a one-cycle `frameStart` pulse. After that pulse, an upstream byte receiver delivers bytes through `byteValid`/`byteData`. The synchronisation byte is consumed upstream, so the first byte this block sees is the protected identifier. A `bitTick` strobe marks every nominal bit time and drives the frame duration budget.

The monitor checks the two identifier parity bits. It decodes the response length from the identifier, accumulates the data bytes and compares the check byte. It also enforces a duration limit of 140 % of the frame's minimum length. One identifier value is reserved as a sleep command; that frame ends right after the identifier. Each frame produces exactly one outcome pulse. The block stays passive until the next `frameStart`.

Top module: `lin_frame_monitor`

## Requirements
- R1: After reset, all five output flags are low.
- R2: The identifier byte carries the 6-bit identifier in bits 5:0, parity P0 in bit 6 and parity P1 in bit 7, with P0 = ID0^ID1^ID2^ID4 and P1 = ~(ID1^ID3^ID4^ID5). On a mismatch, `parityErr` pulses and the frame is abandoned.
- R3: Identifier bits 1:0 select the number of data bytes: 0 selects 1 byte, 1 selects 2, 2 selects 4 and 3 selects 8. The check byte follows the last data byte.
- R4: The check byte must equal the bitwise inverse of the 8-bit sum of the data bytes, where each carry out of bit 7 is added back into bit 0. On a match, `frameOk` pulses.
- R5: When the check byte does not match, `checksumErr` pulses and `frameOk` stays low.
- R6: An identifier of 0x3C with correct parity pulses `sleepCmd` and `frameOk` together and ends the frame. Bytes that follow it produce no flag.
- R7: Ticks are counted from `frameStart`. The limit for a frame with n data bytes is floor(1.4 × (34 + 10·(n+1))), which gives 75, 89, 117 or 173 ticks. Before the identifier has been accepted, the 8-byte limit of 173 applies. A tick that arrives when the elapsed count already equals the limit pulses `timeoutErr` and ends the frame.
- R8: When a timeout tick and a byte arrive in the same cycle, `timeoutErr` is reported and the byte is discarded.
- R9: A `frameStart` pulse in the middle of a frame restarts checking and raises no flag for the abandoned frame.
- R10: Every flag is a one-cycle pulse. It appears in the cycle after the input that decides it. At most one of `frameOk`, `parityErr`, `checksumErr` and `timeoutErr` is high at a time.
- R11: Bytes and ticks received between frames produce no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStart | input | 1 | Pulse at the start of a frame break |
| bitTick | input | 1 | One pulse per nominal bit time |
| byteValid | input | 1 | A received byte is present on `byteData` |
| byteData | input | 8 | Received byte |
| frameOk | output | 1 | Frame completed correctly |
| parityErr | output | 1 | Identifier parity mismatch |
| checksumErr | output | 1 | Check byte mismatch |
| timeoutErr | output | 1 | Frame exceeded its duration budget |
| sleepCmd | output | 1 | Sleep identifier received |

## Verification
The duration budget and byte acceptance can meet in one cycle: the tick that exhausts the budget can coincide with the check byte, the identifier or a data byte. Directed frames place ticks so that the elapsed count lands exactly on the limit. The final byte then arrives either with no tick, after one extra tick, or together with a tick, so both sides of the boundary and the collision are covered. Randomly spaced frames hit the same collisions at other lengths. Every cycle is judged against a bench model written from the requirements, and that model lets the timeout win.

// File: rtl/lin_mon_pkg.sv
package lin_mon_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ID, ST_DATA, ST_CHECK} monState_t;

  typedef struct packed {
    logic clear;
    logic loadId;
    logic addData;
    logic countTick;
  } dpCtrl_t;
endpackage

// File: rtl/lin_mon_dp.sv
module lin_mon_dp
  import lin_mon_pkg::*;
#(
  parameter int HDR_BITS   = 34,
  parameter int BYTE_BITS  = 10,
  parameter int BUDGET_PCT = 140,
  parameter int MAX_LEN    = 8,
  parameter logic [5:0] SLEEP_ID = 6'h3C
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtrl_t    ctl,
  input  logic       bitTick,
  input  logic [7:0] byteData,
  output logic       parityOk,
  output logic       sleepId,
  output logic       lastData,
  output logic       sumMatch,
  output logic       overrun
);
  function automatic int limitFor(int n);
    return ((HDR_BITS + BYTE_BITS * (n + 1)) * BUDGET_PCT) / 100;
  endfunction

  localparam int LIM_MAX = limitFor(MAX_LEN);
  localparam int CNT_W   = $clog2(LIM_MAX + 1) + 1;
  localparam int BC_W    = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] limTab [4];
  for (genvar k = 0; k < 4; k++) begin : g_lim
    assign limTab[k] = CNT_W'(limitFor(1 << k));
  end

  logic [CNT_W-1:0] tickCnt;
  logic [BC_W-1:0]  byteCnt;
  logic [7:0]       acc;
  logic [1:0]       lenCode;
  logic             idLoaded;
  logic [CNT_W-1:0] limitSel;
  logic [8:0]       sumRaw;
  logic [7:0]       sumNext;
  logic [BC_W-1:0]  needM1;

  assign limitSel = idLoaded ? limTab[lenCode] : CNT_W'(LIM_MAX);
  assign overrun  = bitTick && (tickCnt >= limitSel);

  assign parityOk = (byteData[6] == ^{byteData[0], byteData[1], byteData[2], byteData[4]}) &&
                    (byteData[7] == ~^{byteData[1], byteData[3], byteData[4], byteData[5]});
  assign sleepId  = (byteData[5:0] == SLEEP_ID);

  assign sumRaw   = {1'b0, acc} + {1'b0, byteData};
  assign sumNext  = sumRaw[7:0] + {7'd0, sumRaw[8]};
  assign sumMatch = (byteData == ~acc);

  assign needM1   = BC_W'((1 << lenCode) - 1);
  assign lastData = (byteCnt == needM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt  <= '0;
      byteCnt  <= '0;
      acc      <= '0;
      lenCode  <= '0;
      idLoaded <= 1'b0;
    end else if (ctl.clear) begin
      tickCnt  <= '0;
      byteCnt  <= '0;
      acc      <= '0;
      lenCode  <= '0;
      idLoaded <= 1'b0;
    end else begin
      if (ctl.countTick) tickCnt <= tickCnt + 1'b1;
      if (ctl.loadId) begin
        lenCode  <= byteData[1:0];
        idLoaded <= 1'b1;
      end
      if (ctl.addData) begin
        acc     <= sumNext;
        byteCnt <= byteCnt + 1'b1;
      end
    end
  end

  // R3: never more data bytes than the longest class
  p_bytecnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= BC_W'(MAX_LEN));

  // R7: elapsed count only moves by one per tick
  p_tick_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clear && !bitTick) |=> $stable(tickCnt));
endmodule

// File: rtl/lin_mon_ctrl.sv
module lin_mon_ctrl
  import lin_mon_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameStart,
  input  logic    bitTick,
  input  logic    byteValid,
  input  logic    parityOk,
  input  logic    sleepId,
  input  logic    lastData,
  input  logic    sumMatch,
  input  logic    overrun,
  output dpCtrl_t ctl,
  output logic    frameOk,
  output logic    parityErr,
  output logic    checksumErr,
  output logic    timeoutErr,
  output logic    sleepCmd
);
  monState_t state, stateNext;
  logic okN, parN, sumN, toN, slpN;
  logic active;

  assign active = (state != ST_IDLE);

  always_comb begin
    stateNext     = state;
    ctl           = '0;
    okN = 1'b0; parN = 1'b0; sumN = 1'b0; toN = 1'b0; slpN = 1'b0;
    ctl.countTick = active && bitTick && !frameStart;
    if (frameStart) begin
      ctl.clear = 1'b1;
      stateNext = ST_ID;
    end else if (active && overrun) begin
      toN       = 1'b1;
      stateNext = ST_IDLE;
    end else if (byteValid) begin
      unique case (state)
        ST_ID: begin
          if (!parityOk) begin
            parN      = 1'b1;
            stateNext = ST_IDLE;
          end else if (sleepId) begin
            okN       = 1'b1;
            slpN      = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            ctl.loadId = 1'b1;
            stateNext  = ST_DATA;
          end
        end
        ST_DATA: begin
          ctl.addData = 1'b1;
          if (lastData) stateNext = ST_CHECK;
        end
        ST_CHECK: begin
          if (sumMatch) okN = 1'b1;
          else          sumN = 1'b1;
          stateNext = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      frameOk     <= 1'b0;
      parityErr   <= 1'b0;
      checksumErr <= 1'b0;
      timeoutErr  <= 1'b0;
      sleepCmd    <= 1'b0;
    end else begin
      state       <= stateNext;
      frameOk     <= okN;
      parityErr   <= parN;
      checksumErr <= sumN;
      timeoutErr  <= toN;
      sleepCmd    <= slpN;
    end
  end

  p_single_outcome_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({frameOk, parityErr, checksumErr, timeoutErr}));

  p_sleep_ok_r6: assert property (@(posedge clk) disable iff (!rstN)
    sleepCmd |-> frameOk);

  p_timeout_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> $past(bitTick));

  p_parity_src_r2: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |-> $past(state == ST_ID && byteValid));

  p_ok_after_check_r4: assert property (@(posedge clk) disable iff (!rstN)
    (frameOk && !sleepCmd) |-> $past(state == ST_CHECK));
endmodule

// File: rtl/lin_frame_monitor.sv
module lin_frame_monitor
  import lin_mon_pkg::*;
#(
  parameter int HDR_BITS   = 34,
  parameter int BYTE_BITS  = 10,
  parameter int BUDGET_PCT = 140,
  parameter int MAX_LEN    = 8,
  parameter logic [5:0] SLEEP_ID = 6'h3C
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       bitTick,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  output logic       frameOk,
  output logic       parityErr,
  output logic       checksumErr,
  output logic       timeoutErr,
  output logic       sleepCmd
);
  dpCtrl_t ctl;
  logic parityOk, sleepId, lastData, sumMatch, overrun;

  lin_mon_dp #(
    .HDR_BITS(HDR_BITS), .BYTE_BITS(BYTE_BITS), .BUDGET_PCT(BUDGET_PCT),
    .MAX_LEN(MAX_LEN), .SLEEP_ID(SLEEP_ID)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitTick(bitTick), .byteData(byteData),
    .parityOk(parityOk), .sleepId(sleepId), .lastData(lastData),
    .sumMatch(sumMatch), .overrun(overrun)
  );

  lin_mon_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .bitTick(bitTick),
    .byteValid(byteValid), .parityOk(parityOk), .sleepId(sleepId),
    .lastData(lastData), .sumMatch(sumMatch), .overrun(overrun), .ctl(ctl),
    .frameOk(frameOk), .parityErr(parityErr), .checksumErr(checksumErr),
    .timeoutErr(timeoutErr), .sleepCmd(sleepCmd)
  );
endmodule

// File: tb/lin_frame_monitor_bench.sv
module lin_frame_monitor_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0, bitTick = 1'b0, byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic frameOk, parityErr, checksumErr, timeoutErr, sleepCmd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lin_frame_monitor u_lin_frame_monitor (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .bitTick(bitTick),
    .byteValid(byteValid), .byteData(byteData), .frameOk(frameOk),
    .parityErr(parityErr), .checksumErr(checksumErr),
    .timeoutErr(timeoutErr), .sleepCmd(sleepCmd)
  );

  // requirement-level model state
  bit mActive = 0;
  int mPhase = 0, mElapsed = 0, mLimit = 0, mNeed = 0, mGot = 0;
  logic [7:0] mSum = 8'h00;

  function automatic int limitOf(int n);
    return ((34 + 10 * (n + 1)) * 14) / 10;
  endfunction

  function automatic logic [7:0] protect(logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  function automatic logic [7:0] addCarry(logic [7:0] a, logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

  // expected flags {ok, par, sum, to, sleep}
  function automatic logic [4:0] modelStep(bit fs, bit tk, bit bv, logic [7:0] bd);
    logic [4:0] e;
    e = 5'b0;
    if (fs) begin
      mActive = 1; mPhase = 0; mElapsed = 0; mLimit = limitOf(8);
      mGot = 0; mSum = 8'h00;
    end else if (mActive) begin
      if (tk && mElapsed >= mLimit) begin
        e[1] = 1'b1; mActive = 0;
      end else begin
        if (tk) mElapsed++;
        if (bv) begin
          case (mPhase)
            0: begin
              if (bd != protect(bd[5:0])) begin e[3] = 1'b1; mActive = 0; end
              else if (bd[5:0] == 6'h3C) begin e[4] = 1'b1; e[0] = 1'b1; mActive = 0; end
              else begin mNeed = 1 << bd[1:0]; mLimit = limitOf(mNeed); mPhase = 1; end
            end
            1: begin
              mSum = addCarry(mSum, bd); mGot++;
              if (mGot == mNeed) mPhase = 2;
            end
            default: begin
              if (bd == ~mSum) e[4] = 1'b1; else e[2] = 1'b1;
              mActive = 0;
            end
          endcase
        end
      end
    end
    return e;
  endfunction

  task automatic cyc(bit fs, bit tk, bit bv, logic [7:0] bd, string tag);
    logic [4:0] exp, act;
    frameStart = fs; bitTick = tk; byteValid = bv; byteData = bd;
    exp = modelStep(fs, tk, bv, bd);
    @(posedge clk);
    #1;
    frameStart = 0; bitTick = 0; byteValid = 0;
    act = {frameOk, timeoutErr, checksumErr, parityErr, sleepCmd};
    // map model bits to {ok,to,sum,par,sleep}
    exp = {exp[4], exp[1], exp[2], exp[3], exp[0]};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: flags {ok,to,sum,par,sleep} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic runFrame(logic [5:0] id, bit badPar, bit badSum, int gap, int extra,
                          bit tickLast, int abortAt, string tag);
    logic [7:0] idB, sum, b;
    int n, total;
    idB = protect(id);
    if (badPar) idB[7] = ~idB[7];
    n = (id == 6'h3C) ? 2 : (1 << id[1:0]);
    total = n + 2;
    sum = 8'h00;
    cyc(1, 0, 0, 8'h00, tag);
    for (int i = 0; i < total; i++) begin
      if (i == abortAt) begin
        cyc(1, 0, 0, 8'h00, tag);
        return;
      end
      repeat (gap) cyc(0, 1, 0, 8'h00, tag);
      if (i == total - 1) repeat (extra) cyc(0, 1, 0, 8'h00, tag);
      if (i == 0) b = idB;
      else if (i == total - 1) begin
        b = ~sum;
        if (badSum) b = b ^ 8'h01;
      end else begin
        b = 8'($urandom);
        sum = addCarry(sum, b);
      end
      cyc(0, (i == total - 1) && tickLast, 1, b, tag);
    end
    repeat (2) cyc(0, 0, 0, 8'h00, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7041));
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({frameOk, parityErr, checksumErr, timeoutErr, sleepCmd} !== 5'b0) begin
      errors++;
      $display("FAIL R1: reset flags actual %b expected 00000",
               {frameOk, parityErr, checksumErr, timeoutErr, sleepCmd});
    end
    rstN = 1'b1;
    @(posedge clk); #1;
    cyc(0, 0, 0, 8'h00, "R1");
    // R11: traffic between frames
    for (int i = 0; i < 6; i++) cyc(0, i[0], 1, protect(6'h04), "R11");
    // R3/R4 every length class
    runFrame(6'h10, 0, 0, 2, 0, 0, -1, "R3");
    runFrame(6'h21, 0, 0, 2, 0, 0, -1, "R3");
    runFrame(6'h32, 0, 0, 2, 0, 0, -1, "R3");
    runFrame(6'h07, 0, 0, 1, 0, 0, -1, "R4");
    runFrame(6'h0B, 0, 1, 1, 0, 0, -1, "R5");
    runFrame(6'h15, 1, 0, 1, 0, 0, -1, "R2");
    runFrame(6'h3C, 0, 0, 1, 0, 0, -1, "R6");
    // R7 boundary: 75 ticks exactly, then one beyond
    runFrame(6'h04, 0, 0, 25, 0, 0, -1, "R7");
    runFrame(6'h04, 0, 0, 25, 1, 0, -1, "R7");
    runFrame(6'h0F, 0, 0, 17, 0, 0, -1, "R7");
    runFrame(6'h0F, 0, 0, 180, 0, 0, -1, "R7");
    // R8 collision of final byte and exhausting tick
    runFrame(6'h04, 0, 0, 25, 0, 1, -1, "R8");
    runFrame(6'h04, 0, 0, 24, 2, 1, -1, "R8");
    // R9 restart mid-frame
    runFrame(6'h13, 0, 0, 3, 0, 0, 2, "R9");
    runFrame(6'h13, 0, 0, 3, 0, 0, -1, "R9");
    // R10 random mix
    for (int f = 0; f < 150; f++) begin
      runFrame(6'($urandom), ($urandom % 10) == 0, ($urandom % 5) == 0,
               $urandom % 22, $urandom % 3, $urandom % 2,
               (($urandom % 12) == 0) ? 1 + ($urandom % 2) : -1, "R10");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule